// File: doc/BRIEF.md
# SPI Channel with Per-Flag Clear Rules

This block is one SPI channel. It has a transmit buffer and a receive buffer, each 16 bits wide, and a character length that software sets between 1 and 16 bits. Software reaches it through a small register bus. The bus has a word address, a write strobe, a read strobe, write data and combinational read data.

The block runs in one of two modes:
- **Master mode.** The block generates the serial clock. Writing a word to the transmit register starts a character.
- **Slave mode.** An external device supplies the serial clock and an active-low select. Both inputs are synchronised into the local clock domain before use.

Only one clock format is supported. The serial clock idles low, data is sampled on the rising edge, and outgoing data changes after the falling edge. Data moves most significant bit first, starting at bit position length minus 1.

Four interrupt flags report progress: transmit empty, receive full, overrun and transfer end. Each flag is set and cleared by its own rule. Each flag also has an enable bit, and the enabled flags are combined into one interrupt line.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the following values hold:
  - the flag word at address 4 reads 0x0001;
  - the receive register at address 3 reads 0x0000;
  - the control register at address 0 reads 0x0000;
  - the interrupt output is 0;
  - the serial clock output and the serial data output are 0.
- R2: The control register is at address 0. Bit 4 selects master mode. Bits 3:0 hold the character length minus 1. In master mode, writing the transmit register at address 2 starts a character when the channel is idle. During a character:
  - the serial clock idles low, toggles every HALF_DIV clock cycles and gives exactly length rising edges;
  - the data output presents transmit bits from bit length minus 1 down to bit 0, and changes only after a falling edge;
  - higher transmit bits never appear on the data output.
- R3: The serial data input is sampled on each rising serial clock edge. The completed character is stored MSB-first in the receive register at address 3, with every bit at or above the character length reading 0.
- R4: Transmit empty (flag bit 0) goes to 0 when the transmit register is written. It returns to 1 when the shifter takes the buffered word.
- R5: Receive full (flag bit 1) sets when a character completes. It clears when the receive register is read.
- R6: If receive full is already 1 when a character completes, overrun (flag bit 3) sets. The receive register then holds the newer character.
- R7: Transfer end (flag bit 2) sets when a character completes while no transmit word is waiting. If a word is waiting, the next character starts with no idle gap and transfer end stays 0.
- R8: Writing the flag word follows these rules:
  - a 1 in bit 3 clears overrun;
  - a 1 in bit 2 clears transfer end;
  - a 0 in any bit has no effect;
  - bits 0 and 1 ignore writes;
  - the bits that are not flags read as 0.
- R9: Busy (flag bit 7) behaves differently in the two modes:
  - in master mode it reads 1 while a character is in progress;
  - in slave mode it reads 1 while the synchronised select is low.
- R10: The interrupt enable register is at address 1. Bits 3:0 use the same positions as the flags. The interrupt output is 1 exactly when some flag and its enable bit are both 1.
- R11: A write to the transmit register while transmit empty is 0 is ignored. Both the buffer and its read-back at address 2 keep the earlier word.
- R12: In slave mode, the following happens in order:
  - the shifter takes the buffered word when select falls, or takes zeros if no word is waiting;
  - it shifts on the external clock with the same edge rules as master mode;
  - after length falling edges it completes a character with the same flag rules.
- R13: When a character completes in the same cycle as a receive register read:
  - the read returns the earlier data;
  - receive full stays 1;
  - overrun sets, judged on the receive full value before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the receive register) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from the address |
| sclk_o | output | 1 | Serial clock in master mode, 0 in slave mode |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | External serial clock in slave mode |
| ss_n_i | input | 1 | Active-low select in slave mode |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
Two events can land in the same cycle: a character completing and software reading the receive register. The bench provokes this deterministically with a 1-bit master character. It waits for the only rising serial clock edge, counts HALF_DIV clock cycles forward, and times the receive read to fall in the completing cycle. The result is judged on three points:
- the read returns the earlier bit;
- receive full stays 1;
- overrun sets.

A second test covers another collision. It writes a new transmit word while the previous word is still shifting, and checks the back-to-back handoff: there is no transfer end between the two characters, and all 16 bits appear in order on the data output.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int DW   = 16;
    localparam int LENW = 4;
    localparam int AW   = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_IEN  = 3'd1;
    localparam logic [AW-1:0] A_TXD  = 3'd2;
    localparam logic [AW-1:0] A_RXD  = 3'd3;
    localparam logic [AW-1:0] A_FLAG = 3'd4;

    localparam int F_TBE  = 0;
    localparam int F_RBF  = 1;
    localparam int F_TEND = 2;
    localparam int F_OE   = 3;
    localparam int F_BUSY = 7;

    typedef struct packed {
        logic oe;
        logic tend;
        logic rbf;
        logic tbe;
    } flags_t;

    typedef struct packed {
        logic            master;
        logic [LENW-1:0] len_m1;
    } ctrl_t;

    typedef struct packed {
        logic          load;
        logic          done;
        logic [DW-1:0] rx_word;
    } xfer_evt_t;

    function automatic logic [DW-1:0] len_mask(input logic [LENW-1:0] m1);
        len_mask = {DW{1'b1}} >> (LENW'(DW - 1) - m1);
    endfunction

    function automatic logic [DW-1:0] flag_word(input flags_t f, input logic busy);
        logic [DW-1:0] w;
        w         = '0;
        w[F_BUSY] = busy;
        w[F_OE]   = f.oe;
        w[F_TEND] = f.tend;
        w[F_RBF]  = f.rbf;
        w[F_TBE]  = f.tbe;
        flag_word = w;
    endfunction
endpackage

// File: rtl/spi_flag_regs.sv
module spi_flag_regs
    import spi_flag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  xfer_evt_t     evt,
    input  logic          busy,
    output ctrl_t         cfg,
    output logic [DW-1:0] tx_buf,
    output logic          tx_pending,
    output logic          irq
);
    flags_t        flags;
    logic [3:0]    ien;
    logic [DW-1:0] rx_buf;
    logic          tx_wr, rx_rd, flag_wr;

    assign tx_wr      = wr_en && (addr == A_TXD) && flags.tbe;
    assign rx_rd      = rd_en && (addr == A_RXD);
    assign flag_wr    = wr_en && (addr == A_FLAG);
    assign tx_pending = !flags.tbe;
    assign irq        = |(flags & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            ien    <= '0;
            tx_buf <= '0;
            rx_buf <= '0;
            flags  <= '{oe: 1'b0, tend: 1'b0, rbf: 1'b0, tbe: 1'b1};
        end else begin
            if (wr_en && addr == A_CTRL) cfg <= wdata[LENW:0];
            if (wr_en && addr == A_IEN)  ien <= wdata[3:0];
            if (tx_wr)    tx_buf <= wdata;
            if (evt.done) rx_buf <= evt.rx_word;

            if (evt.load)      flags.tbe <= 1'b1;
            else if (tx_wr)    flags.tbe <= 1'b0;

            if (evt.done)      flags.rbf <= 1'b1;
            else if (rx_rd)    flags.rbf <= 1'b0;

            if (evt.done && flags.rbf)          flags.oe <= 1'b1;
            else if (flag_wr && wdata[F_OE])    flags.oe <= 1'b0;

            if (evt.done && flags.tbe)          flags.tend <= 1'b1;
            else if (flag_wr && wdata[F_TEND])  flags.tend <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = DW'(cfg);
            A_IEN:   rdata = DW'(ien);
            A_TXD:   rdata = tx_buf;
            A_RXD:   rdata = rx_buf;
            A_FLAG:  rdata = flag_word(flags, busy);
            default: rdata = '0;
        endcase
    end

    // R5
    rbf_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> flags.rbf);
    // R6
    oe_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.done && flags.rbf) |=> flags.oe);
    // R11
    load_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        evt.load |-> !flags.tbe);
    // R4
    tbe_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        evt.load |=> flags.tbe);
    // R8
    tend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.tend && !(flag_wr && wdata[F_TEND])) |=> flags.tend);
endmodule

// File: rtl/spi_flag_shifter.sv
module spi_flag_shifter
    import spi_flag_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         cfg,
    input  logic [DW-1:0] tx_buf,
    input  logic          tx_pending,
    input  logic          sclk_i,
    input  logic          ss_n_i,
    input  logic          sdi_i,
    output logic          sclk_o,
    output logic          sdo_o,
    output logic          busy,
    output xfer_evt_t     evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef enum logic {M_IDLE, M_SHIFT} mstate_t;

    mstate_t         st;
    logic [CW-1:0]   div;
    logic            sclk_r, sample;
    logic [DW-1:0]   shreg;
    logic [LENW-1:0] bitcnt;
    logic [2:0]      sck_q, ss_q;
    logic tick, m_rise, m_fall, s_rise, s_fall, ss_low, ss_fell;
    logic rise, fall, done, m_start, reload;

    always_comb begin
        tick    = (div == CW'(HALF_DIV - 1));
        m_rise  = cfg.master && (st == M_SHIFT) && tick && !sclk_r;
        m_fall  = cfg.master && (st == M_SHIFT) && tick && sclk_r;
        ss_low  = !ss_q[1];
        ss_fell = !ss_q[1] && ss_q[2];
        s_rise  = sck_q[1] && !sck_q[2];
        s_fall  = !sck_q[1] && sck_q[2];
        rise    = cfg.master ? m_rise : (ss_low && s_rise);
        fall    = cfg.master ? m_fall : (ss_low && s_fall);
        done    = fall && (bitcnt == '0);
        m_start = cfg.master && (st == M_IDLE) && tx_pending;
        reload  = m_start || done || (!cfg.master && ss_fell);
        busy    = cfg.master ? (st == M_SHIFT) : ss_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= M_IDLE;
            div    <= '0;
            sclk_r <= 1'b0;
            sample <= 1'b0;
            shreg  <= '0;
            bitcnt <= '0;
            sck_q  <= 3'b000;
            ss_q   <= 3'b111;
        end else begin
            sck_q <= {sck_q[1:0], sclk_i};
            ss_q  <= {ss_q[1:0], ss_n_i};

            if (cfg.master && st == M_SHIFT) div <= tick ? '0 : div + 1'b1;
            else                             div <= '0;

            if (m_rise)                    sclk_r <= 1'b1;
            else if (m_fall || !cfg.master) sclk_r <= 1'b0;

            if (rise) sample <= sdi_i;

            if (reload) begin
                shreg  <= tx_pending ? tx_buf : '0;
                bitcnt <= cfg.len_m1;
            end else if (fall) begin
                shreg  <= {shreg[DW-2:0], sample};
                bitcnt <= bitcnt - 1'b1;
            end else if (!cfg.master && !ss_low) begin
                bitcnt <= cfg.len_m1;
            end

            if (!cfg.master)                 st <= M_IDLE;
            else if (m_start)                st <= M_SHIFT;
            else if (done && !tx_pending)    st <= M_IDLE;
        end
    end

    assign sclk_o      = sclk_r;
    assign sdo_o       = busy ? shreg[cfg.len_m1] : 1'b0;
    assign evt.load    = reload && tx_pending;
    assign evt.done    = done;
    assign evt.rx_word = {shreg[DW-2:0], sample} & len_mask(cfg.len_m1);

    // R2
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.master && !busy) |-> (!sclk_o && !sdo_o));
    // R2
    clk_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> busy);
    // R12
    slave_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.master |=> !sclk_o);
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sclk_o,
    output logic          sdo_o,
    input  logic          sdi_i,
    input  logic          sclk_i,
    input  logic          ss_n_i,
    output logic          irq_o
);
    ctrl_t         cfg;
    xfer_evt_t     evt;
    logic [DW-1:0] tx_buf;
    logic          tx_pending, busy;

    spi_flag_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .evt(evt), .busy(busy),
        .cfg(cfg), .tx_buf(tx_buf), .tx_pending(tx_pending), .irq(irq_o)
    );

    spi_flag_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .cfg(cfg), .tx_buf(tx_buf), .tx_pending(tx_pending),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .busy(busy), .evt(evt)
    );
endmodule

// File: tb/spi_flag_ctrl_tb.sv
module spi_flag_ctrl_tb;
    localparam int HALF = 2;
    localparam logic [2:0] AC = 3'd0, AI = 3'd1, AT = 3'd2, AR = 3'd3, AF = 3'd4;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sclk_o, sdo_o, irq;
    logic        sclk_i = 1'b0, ss_n = 1'b1, sdi_slv = 1'b0, sdi_sel = 1'b0;
    logic        sdi_mst, sdi;

    int checks = 0, fails = 0;
    int pos_total = 0, neg_total = 0, neg_base = 0, cur_m1 = 0;
    logic [15:0] cap = '0, sdi_word = '0;

    assign sdi = sdi_sel ? sdi_slv : sdi_mst;

    spi_flag_ctrl #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .sdi_i(sdi), .sclk_i(sclk_i), .ss_n_i(ss_n), .irq_o(irq)
    );

    always @(posedge sclk_o) begin
        cap = {cap[14:0], sdo_o};
        pos_total++;
    end
    always @(negedge sclk_o) neg_total++;

    always_comb begin
        int d, idx;
        d   = neg_total - neg_base;
        idx = (d > cur_m1) ? 0 : cur_m1 - d;
        sdi_mst = sdi_word[idx[3:0]];
    end

    function automatic logic [15:0] msk(input int m1);
        msk = 16'hFFFF >> (15 - m1);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] f;
        for (int k = 0; k < 400; k++) begin
            rd_reg(AF, f);
            if (f[1] && !f[7]) break;
        end
    endtask

    task automatic master_xfer(input int m1, input logic [15:0] txw, input logic [15:0] rxw);
        logic [15:0] v;
        int pb;
        cur_m1 = m1; sdi_word = rxw; neg_base = neg_total; pb = pos_total;
        wr_reg(AT, txw);
        wait_idle();
        chk($sformatf("R2 edges len=%0d", m1 + 1), 16'(pos_total - pb), 16'(m1 + 1));
        chk($sformatf("R2 sdo len=%0d", m1 + 1), cap & msk(m1), txw & msk(m1));
        rd_reg(AF, v);  chk("R5 R7 flags after char", v, 16'h0007);
        rd_reg(AR, v);  chk($sformatf("R3 rxd len=%0d", m1 + 1), v, rxw & msk(m1));
        rd_reg(AF, v);  chk("R5 rbf cleared by read", v, 16'h0005);
        wr_reg(AF, 16'h0004);
        rd_reg(AF, v);  chk("R8 tend w1c", v, 16'h0001);
    endtask

    initial begin
        logic [15:0] v, scap;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(AF, v); chk("R1 flags", v, 16'h0001);
        rd_reg(AR, v); chk("R1 rxd", v, 16'h0000);
        rd_reg(AC, v); chk("R1 ctrl", v, 16'h0000);
        chk("R1 pins", {13'b0, irq, sclk_o, sdo_o}, 16'h0000);

        // R2 R3 sweep over every length
        for (int m1 = 0; m1 < 16; m1++) begin
            wr_reg(AC, 16'h0010 | 16'(m1));
            for (int p = 0; p < 3; p++) begin
                logic [15:0] t, r;
                t = 16'(16'h9E37 * (p + 1)) ^ 16'(m1 << 5);
                r = {t[6:0], t[15:7]} ^ 16'h5A5A;
                master_xfer(m1, t, r);
            end
        end

        // R7 back-to-back, R4 handoff, R6 overrun
        wr_reg(AC, 16'h0017);
        cur_m1 = 7; sdi_word = 16'h00C5; neg_base = neg_total;
        wr_reg(AT, 16'h3CA5);
        rd_reg(AF, v); chk("R4 R9 loaded and busy", v, 16'h0081);
        wr_reg(AT, 16'h5A96);
        for (int k = 0; k < 400; k++) begin rd_reg(AF, v); if (v[1]) break; end
        chk("R7 no tend between chars", v & 16'h0084, 16'h0080);
        wait_idle();
        chk("R7 back-to-back bits", cap, 16'hA596);
        rd_reg(AF, v); chk("R6 overrun flags", v, 16'h000F);
        rd_reg(AR, v); chk("R6 newest data kept", v, 16'h00FF);
        wr_reg(AF, 16'h000C);

        // R13 completion coinciding with receive read
        wr_reg(AC, 16'h0010);
        cur_m1 = 0; sdi_word = 16'h0001; neg_base = neg_total;
        wr_reg(AT, 16'h0000);
        wait_idle();
        sdi_word = 16'h0000; neg_base = neg_total;
        wr_reg(AT, 16'h0001);
        @(posedge sclk_o);
        repeat (HALF - 1) @(posedge clk);
        rd_reg(AR, v); chk("R13 read returns old data", v, 16'h0001);
        rd_reg(AF, v); chk("R13 rbf kept and oe set", v, 16'h000F);
        wr_reg(AF, 16'h0003);
        rd_reg(AF, v); chk("R8 bits 0 1 ignore writes", v, 16'h000F);
        rd_reg(AR, v); chk("R13 new data", v, 16'h0000);

        // R10 interrupt enable sweep, flags = oe tend tbe
        for (int e = 0; e < 16; e++) begin
            wr_reg(AI, 16'(e));
            chk($sformatf("R10 irq en=%0d", e), {15'b0, irq}, {15'b0, |(4'(e) & 4'b1101)});
        end

        // R8 write-one-to-clear rules
        wr_reg(AF, 16'h0000);
        rd_reg(AF, v); chk("R8 zero write no effect", v, 16'h000D);
        wr_reg(AF, 16'h0008);
        rd_reg(AF, v); chk("R8 oe w1c", v, 16'h0005);
        wr_reg(AF, 16'h0004);
        rd_reg(AF, v); chk("R8 tend w1c", v, 16'h0001);
        chk("R10 irq from tbe", {15'b0, irq}, 16'h0001);
        wr_reg(AI, 16'h0000);

        // R12 slave mode, R11 ignored write, R9 busy on select
        sdi_sel = 1'b1;
        wr_reg(AC, 16'h0005);
        wr_reg(AT, 16'h2D5A);
        rd_reg(AF, v); chk("R4 tbe cleared by write", v, 16'h0000);
        wr_reg(AT, 16'h0FFF);
        rd_reg(AT, v); chk("R11 write ignored", v, 16'h2D5A);
        @(negedge clk); ss_n = 1'b0;
        repeat (8) @(negedge clk);
        rd_reg(AF, v); chk("R9 R12 select busy and load", v, 16'h0081);
        scap = '0;
        for (int i = 5; i >= 0; i--) begin
            sdi_slv = 16'h0013 >> i;
            repeat (6) @(negedge clk);
            scap = {scap[14:0], sdo_o};
            sclk_i = 1'b1;
            repeat (6) @(negedge clk);
            sclk_i = 1'b0;
            repeat (6) @(negedge clk);
        end
        chk("R12 slave sdo", scap & 16'h003F, 16'h001A);
        rd_reg(AF, v); chk("R12 slave flags", v, 16'h0087);
        rd_reg(AR, v); chk("R12 R3 slave rxd", v, 16'h0013);
        ss_n = 1'b1;
        repeat (8) @(negedge clk);
        rd_reg(AF, v); chk("R9 busy drops with select", v, 16'h0005);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule